// File: doc/BRIEF.md
# Four-Port Shared RAM with Per-Port Write Inhibit

A synchronous shared memory of 2048 words by 8 bits with four independent ports. Each port has its own address, write data, registered read data with a drive-enable flag standing in for a tri-state bus, an active-low select, an active-low output enable, a read/write select and an active-low write-inhibit input. Every port may read or write any word in any cycle. The block does no arbitration: external logic is expected to keep writers apart, and it can hold off any single port's writes through that port's inhibit input without stopping its reads.

All accesses are sampled on the rising clock edge. Read data and its drive flag are registered, so they appear one cycle after the request. When two or more effective writes hit the same word in one cycle, a combinational conflict flag is raised for that cycle. The lowest-numbered writing port's data is stored, so the result is repeatable in tests.

Top module: `quad_port_ram`

## Requirements
- R1: Any of the four ports can write any of the 2048 words, and any port can read the stored value in any later cycle.
- R2: A read requested at a rising edge puts the stored data on `rd_data` with the port's `rd_drive` bit set (1) after that edge, one cycle of latency.
- R3: A port with `cs_n` high (1) does no access: nothing is written, and after the edge its `rd_drive` is 0 and its `rd_data` slice is all zeros.
- R4: A write happens at an edge only when the port has `cs_n` = 0, `rw` = 0 (0 means write, 1 means read) and `wr_inh_n` = 1.
- R5: While `wr_inh_n` is 0 the port's writes leave memory unchanged, yet a read on that port (`rw` = 1) still returns data.
- R6: A read request with `oe_n` high (1) leaves `rd_drive` at 0 and `rd_data` at zero after the edge; `oe_n` does not affect writes.
- R7: A port that is writing (`cs_n` = 0, `rw` = 0) never has `rd_drive` set in the following cycle.
- R8: `collide` is 1 in the same cycle exactly when at least two ports have an effective write (R4) to the same address; inhibited or deselected ports do not count.
- R9: On a same-address write conflict, the lowest-numbered writing port's data is stored.
- R10: A read and a write to the same address in one cycle on different ports return the data held before that write.

Port fields are packed with port p at bits [p*W +: W] of each vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the read registers |
| cs_n | input | 4 | Active-low select, one bit per port |
| rw | input | 4 | 1 = read, 0 = write, per port |
| oe_n | input | 4 | Active-low output enable per port |
| wr_inh_n | input | 4 | Active-low write inhibit per port |
| addr | input | 44 | Four 11-bit addresses |
| wr_data | input | 32 | Four 8-bit write data words |
| rd_data | output | 32 | Four 8-bit registered read data words, zero when not driven |
| rd_drive | output | 4 | Per-port flag that read data is being driven |
| collide | output | 1 | Same-cycle same-address write conflict |

## Verification
A wrong word in the array surfaces on `rd_data` one cycle after any port reads it, so the bench fills every word with an address-derived pattern and reads every word back through every port, each port offset by a quarter of the array. A bad enable decode shows as `rd_drive` or zero data one cycle after the request; wrong write gating or conflict ordering shows on the first readback after the offending cycle, and a wrong conflict flag shows combinationally in the same cycle.

// File: rtl/quad_port_ram.sv
module quad_port_ram #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int NP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    cs_n,
  input  logic [NP-1:0]    rw,
  input  logic [NP-1:0]    oe_n,
  input  logic [NP-1:0]    wr_inh_n,
  input  logic [NP*AW-1:0] addr,
  input  logic [NP*DW-1:0] wr_data,
  output logic [NP*DW-1:0] rd_data,
  output logic [NP-1:0]    rd_drive,
  output logic             collide
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  wire [NP-1:0] wr_go = ~cs_n & ~rw & wr_inh_n;
  wire [NP-1:0] rd_go = ~cs_n & rw & ~oe_n;

  always_comb begin
    collide = 1'b0;
    for (int i = 0; i < NP; i++)
      for (int j = i + 1; j < NP; j++)
        if (wr_go[i] && wr_go[j] && addr[i*AW +: AW] == addr[j*AW +: AW])
          collide = 1'b1;
  end

  // descending order: the lowest port's update is the last one scheduled
  always_ff @(posedge clk) begin
    for (int p = NP - 1; p >= 0; p--)
      if (wr_go[p]) mem[addr[p*AW +: AW]] <= wr_data[p*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_drive <= '0;
      rd_data  <= '0;
    end else begin
      rd_drive <= rd_go;
      for (int p = 0; p < NP; p++)
        rd_data[p*DW +: DW] <= rd_go[p] ? mem[addr[p*AW +: AW]] : '0;
    end
  end

  AST_CONFLICT_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> $countones(wr_go) >= 2); // R8

  for (genvar g = 0; g < NP; g++) begin : g_chk
    AST_DESELECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n[g] |=> !rd_drive[g]); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_drive[g] |-> rd_data[g*DW +: DW] == '0); // R3
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n[g] && rw[g] && !oe_n[g]) |=> rd_drive[g]); // R2
    AST_OE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n[g] |=> !rd_drive[g]); // R6
    AST_WRITER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n[g] && !rw[g]) |=> !rd_drive[g]); // R7
  end
endmodule

// File: tb/quad_port_ram_bench.sv
module quad_port_ram_bench;
  localparam int AW = 11, DW = 8, NP = 4, DEPTH = 2048;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] cs_n = '1, rw = '1, oe_n = '1, wr_inh_n = '1;
  logic [NP*AW-1:0] addr = '0;
  logic [NP*DW-1:0] wr_data = '0;
  logic [NP*DW-1:0] rd_data;
  logic [NP-1:0] rd_drive;
  logic collide;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  quad_port_ram u_quad_port_ram (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw),
    .oe_n(oe_n), .wr_inh_n(wr_inh_n), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_drive(rd_drive), .collide(collide));

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) ^ (a >> 3));
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = '1; rw = '1; oe_n = '1; wr_inh_n = '1;
  endtask

  task automatic setp(int p, bit c, bit r, bit o, bit inh, int a, int d);
    cs_n[p] = c; rw[p] = r; oe_n[p] = o; wr_inh_n[p] = inh;
    addr[p*AW +: AW] = AW'(a); wr_data[p*DW +: DW] = DW'(d);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic rd(int p, int a, int exp, string req);
    setp(p, 0, 1, 0, 1, a, 0);
    step();
    chk(req, rd_drive[p], 1);
    chk(req, rd_data[p*DW +: DW], exp);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R3 reset drive", rd_drive, 0);
    chk("R3 reset data", rd_data, 0);
    chk("R8 reset collide", collide, 0);

    // R1 R4: fill every word, four ports in parallel
    for (int i = 0; i < DEPTH / NP; i++) begin
      for (int p = 0; p < NP; p++) setp(p, 0, 0, p[0], 1, i * NP + p, pat(i * NP + p));
      #1 chk("R8 distinct addresses", collide, 0);
      step();
      chk("R7 writer not driving", rd_drive, 0);
    end

    // R1 R2: every port reads every word
    for (int i = 0; i < DEPTH; i++) begin
      for (int p = 0; p < NP; p++) setp(p, 0, 1, 0, 1, (i + p * 512) % DEPTH, 0);
      step();
      for (int p = 0; p < NP; p++) begin
        chk("R2 drive", rd_drive[p], 1);
        chk("R1 readback", rd_data[p*DW +: DW], pat((i + p * 512) % DEPTH));
      end
    end

    // R3: deselected write attempt
    setp(0, 1, 0, 0, 1, 5, 8'hA5);
    step();
    chk("R3 deselect drive", rd_drive[0], 0);
    chk("R3 deselect data", rd_data[7:0], 0);
    rd(1, 5, pat(5), "R3 no write");

    // R5: inhibited write, read still works under inhibit
    setp(0, 0, 0, 1, 0, 6, 8'h3C);
    step();
    rd(2, 6, pat(6), "R5 inhibited write blocked");
    setp(3, 0, 1, 0, 0, 7, 0);
    step();
    chk("R5 read under inhibit drive", rd_drive[3], 1);
    chk("R5 read under inhibit data", rd_data[31:24], pat(7));
    setp(0, 0, 0, 1, 1, 6, 8'h3C);
    step();
    rd(2, 6, 8'h3C, "R5 write after inhibit released");

    // R6: oe high hides read, write with oe high works
    setp(1, 0, 1, 1, 1, 8, 0);
    step();
    chk("R6 oe off drive", rd_drive[1], 0);
    chk("R6 oe off data", rd_data[15:8], 0);
    setp(1, 0, 0, 1, 1, 9, 8'h77);
    step();
    rd(0, 9, 8'h77, "R6 write with oe high");

    // R4: rw high with select low is a read, not a write
    setp(2, 0, 1, 1, 1, 11, 8'hEE);
    step();
    rd(3, 11, pat(11), "R4 read does not write");

    // R8 R9: conflicts
    setp(1, 0, 0, 0, 1, 10, 8'h11);
    setp(2, 0, 0, 0, 1, 10, 8'h22);
    #1 chk("R8 two-way collide", collide, 1);
    step();
    rd(0, 10, 8'h11, "R9 lowest wins 1 vs 2");
    setp(3, 0, 0, 0, 1, 12, 8'h33);
    setp(1, 0, 0, 0, 1, 12, 8'h44);
    setp(2, 0, 0, 0, 1, 12, 8'h55);
    #1 chk("R8 three-way collide", collide, 1);
    step();
    rd(0, 12, 8'h44, "R9 lowest wins 1/2/3");
    setp(0, 0, 0, 0, 1, 13, 8'h66);
    setp(3, 0, 0, 0, 0, 13, 8'h99);
    #1 chk("R8 inhibited not counted", collide, 0);
    step();
    rd(1, 13, 8'h66, "R5 inhibited loser");
    setp(2, 1, 0, 0, 1, 14, 8'h12);
    setp(3, 0, 0, 0, 1, 14, 8'h34);
    #1 chk("R8 deselected not counted", collide, 0);
    step();
    rd(0, 14, 8'h34, "R8 sole writer stored");

    // R10: read-before-write
    setp(0, 0, 0, 1, 1, 20, 8'hC3);
    setp(3, 0, 1, 0, 1, 20, 0);
    step();
    chk("R10 old data", rd_data[31:24], pat(20));
    rd(2, 20, 8'hC3, "R10 new data next");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule